// File: doc/BRIEF.md
# Mask-Driven Vector Expand/Compress Unit

The unit moves 32-bit elements between a packed form (elements stored back to back from position 0) and a sparse vector of 16 lanes, steered by a 16-bit lane mask. In expand mode, the packed source elements are placed in order into the lanes whose mask bit is set. In compress mode, the selected lanes of a sparse source are gathered in ascending lane order into the lowest result positions. All other result positions are filled from an old destination vector (merging) or cleared (zeroing).

Besides the result, the unit reports how many elements were transferred. It also gives a per-position access-valid vector that marks exactly which packed positions are touched. An external memory agent can use that vector to suppress every access beyond the last element in use.

The block is a sequencer that visits one lane per clock. Its states are ST_IDLE, ST_SCAN and ST_DONE. The transitions are:
- ST_IDLE to ST_SCAN when start is seen.
- ST_SCAN to itself while the lane counter is below the last lane.
- ST_SCAN to ST_DONE after the last lane.
- ST_DONE to ST_IDLE unconditionally.

Top module: `vxc_unit`

## Requirements
- R1: In expand mode (op_compress=0), packed element j (src_vec bits [32j+31:32j]) is written to the lane that holds the (j+1)-th set mask bit, counting from lane 0 upward; mask 0x4DB1 places elements 0..7 into lanes 0, 4, 5, 7, 8, 10, 11, 14.
- R2: In expand mode, a lane whose mask bit is 0 holds the old_vec lane when zeroing=0 and holds zero when zeroing=1.
- R3: In compress mode (op_compress=1), the selected source lanes are written to result positions 0, 1, 2, ... in ascending lane order.
- R4: In compress mode, result positions at or above the transferred count hold old_vec when zeroing=0 and zero when zeroing=1.
- R5: When done is high, count equals the number of set bits in the accepted mask.
- R6: When done is high, access_valid bit j is 1 exactly when j < count, so no packed position beyond the last transferred element is marked.
- R7: An all-zero mask gives count 0 and access_valid 0, and the whole result comes from old_vec (merging) or is zero (zeroing).
- R8: start is accepted only in ST_IDLE. done is a one-cycle pulse on the 16th rising edge after the accepting edge, and busy is high from the accepting edge through the done cycle.
- R9: start pulses and input changes while busy is high are ignored; the running operation finishes with the values captured at acceptance.
- R10: result, count and access_valid hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation; sampled in ST_IDLE only |
| op_compress | input | 1 | 0 = expand, 1 = compress |
| zeroing | input | 1 | 1 = clear unfilled positions, 0 = keep old_vec |
| mask | input | 16 | Lane select mask, bit i for lane i |
| src_vec | input | 512 | Source elements, element i at bits [32i+31:32i] |
| old_vec | input | 512 | Old destination used in merging mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 512 | Result vector, lane i at bits [32i+31:32i] |
| count | output | 5 | Number of transferred elements |
| access_valid | output | 16 | Packed positions touched by the operation |

## Verification
The bound checker watches the control side on every cycle. On each done it checks that the count matches the popcount of the mask it captured at acceptance (R5), that access_valid is a contiguous low run whose length equals the count (R6), and that an empty mask marks nothing (R7). It also checks that done lasts a single cycle and that busy rises only on an accepted start and does not drop mid-scan (R8, R9). The placement of data (R1 to R4), the filling of unselected positions, the holding of outputs after done (R10) and the exact done latency can only be shown by the bench's scenarios. Those scenarios compare the result against vectors that the bench computes itself.

// File: rtl/vxc_pkg.sv
package vxc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } vxc_state_e;
endpackage

// File: rtl/vxc_ctrl.sv
module vxc_ctrl
    import vxc_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [LANES-1:0]               mask_in,
    output logic                           load,
    output logic                           step,
    output logic                           sel,
    output logic [$clog2(LANES)-1:0]       lane,
    output logic [$clog2(LANES)-1:0]       ptr,
    output logic [$clog2(LANES+1)-1:0]     count,
    output logic                           busy,
    output logic                           done
);
    localparam int LW = $clog2(LANES);
    localparam int CW = $clog2(LANES+1);

    vxc_state_e          state_q, state_d;
    logic [LW-1:0]       lane_q;
    logic [CW-1:0]       ptr_q;
    logic [LANES-1:0]    mask_q;
    logic                last_lane;

    assign last_lane = (lane_q == LW'(LANES-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_SCAN;
            ST_SCAN: if (last_lane) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_SCAN: step = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // lane and packed-position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            ptr_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            lane_q <= '0;
            ptr_q  <= '0;
            mask_q <= mask_in;
        end else if (step) begin
            lane_q <= lane_q + 1'b1;
            if (mask_q[lane_q]) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign sel   = mask_q[lane_q];
    assign lane  = lane_q;
    assign ptr   = ptr_q[LW-1:0];
    assign count = ptr_q;
endmodule

// File: rtl/vxc_lanes.sv
module vxc_lanes #(
    parameter int LANES = 16,
    parameter int EW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       step,
    input  logic                       sel,
    input  logic                       op_compress,
    input  logic                       zeroing,
    input  logic [LANES*EW-1:0]        src_vec,
    input  logic [LANES*EW-1:0]        old_vec,
    input  logic [$clog2(LANES)-1:0]   lane,
    input  logic [$clog2(LANES)-1:0]   ptr,
    output logic [LANES*EW-1:0]        result
);
    localparam int LW = $clog2(LANES);

    logic [EW-1:0] src_q [LANES];
    logic [EW-1:0] res_q [LANES];
    logic          op_q;
    logic          wr_en;
    logic [LW-1:0] wr_idx;
    logic [EW-1:0] wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= 1'b0;
        end else if (load) begin
            op_q <= op_compress;
        end
    end

    // expand: lane-indexed write of the next packed element
    // compress: packed-position write of the current lane
    always_comb begin
        wr_en   = step && sel;
        wr_idx  = op_q ? ptr : lane;
        wr_data = op_q ? src_q[lane] : src_q[ptr];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[i] <= '0;
            end else if (load) begin
                src_q[i] <= src_vec[i*EW +: EW];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (load) begin
                res_q[i] <= zeroing ? '0 : old_vec[i*EW +: EW];
            end else if (wr_en && (wr_idx == LW'(i))) begin
                res_q[i] <= wr_data;
            end
        end

        assign result[i*EW +: EW] = res_q[i];
    end
endmodule

// File: rtl/vxc_access_gen.sv
module vxc_access_gen #(
    parameter int LANES = 16
) (
    input  logic [$clog2(LANES+1)-1:0] count,
    output logic [LANES-1:0]           access_valid
);
    localparam int CW = $clog2(LANES+1);

    for (genvar j = 0; j < LANES; j++) begin : g_pos
        assign access_valid[j] = (count > CW'(j));
    end
endmodule

// File: rtl/vxc_unit.sv
module vxc_unit #(
    parameter int LANES = 16,
    parameter int EW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         op_compress,
    input  logic                         zeroing,
    input  logic [LANES-1:0]             mask,
    input  logic [LANES*EW-1:0]          src_vec,
    input  logic [LANES*EW-1:0]          old_vec,
    output logic                         busy,
    output logic                         done,
    output logic [LANES*EW-1:0]          result,
    output logic [$clog2(LANES+1)-1:0]   count,
    output logic [LANES-1:0]             access_valid
);
    localparam int LW = $clog2(LANES);

    logic          load;
    logic          step;
    logic          sel;
    logic [LW-1:0] lane;
    logic [LW-1:0] ptr;

    vxc_ctrl #(.LANES(LANES)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mask_in (mask),
        .load    (load),
        .step    (step),
        .sel     (sel),
        .lane    (lane),
        .ptr     (ptr),
        .count   (count),
        .busy    (busy),
        .done    (done)
    );

    vxc_lanes #(.LANES(LANES), .EW(EW)) i_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .sel         (sel),
        .op_compress (op_compress),
        .zeroing     (zeroing),
        .src_vec     (src_vec),
        .old_vec     (old_vec),
        .lane        (lane),
        .ptr         (ptr),
        .result      (result)
    );

    vxc_access_gen #(.LANES(LANES)) i_access (
        .count        (count),
        .access_valid (access_valid)
    );
endmodule

// File: rtl/vxc_unit_chk.sv
module vxc_unit_chk #(
    parameter int LANES = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic [LANES-1:0]             mask,
    input logic                         busy,
    input logic                         done,
    input logic [$clog2(LANES+1)-1:0]   count,
    input logic [LANES-1:0]             access_valid
);
    logic [LANES-1:0] taken_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_mask <= '0;
        end else if (start && !busy) begin
            taken_mask <= mask;
        end
    end

    a_r5_count_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(count) == $countones(taken_mask)));

    a_r6_access_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(access_valid) == int'(count)));

    a_r6_access_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((access_valid & (access_valid + 1'b1)) == '0));

    a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (taken_mask == '0)) |-> ((access_valid == '0) && (count == '0)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind vxc_unit vxc_unit_chk #(.LANES(LANES)) i_vxc_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mask         (mask),
    .busy         (busy),
    .done         (done),
    .count        (count),
    .access_valid (access_valid)
);

// File: tb/test_vxc_unit.sv
module test_vxc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int EW    = 32;
    localparam int VW    = LANES*EW;
    localparam int CW    = $clog2(LANES+1);
    localparam int LATENCY = LANES + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            op_compress = 1'b0;
    logic            zeroing = 1'b0;
    logic [LANES-1:0] mask = '0;
    logic [VW-1:0]   src_vec = '0;
    logic [VW-1:0]   old_vec = '0;
    logic            busy;
    logic            done;
    logic [VW-1:0]   result;
    logic [CW-1:0]   count;
    logic [LANES-1:0] access_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vxc_unit #(.LANES(LANES), .EW(EW)) i_vxc_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_compress(op_compress),
        .zeroing(zeroing), .mask(mask), .src_vec(src_vec), .old_vec(old_vec),
        .busy(busy), .done(done), .result(result), .count(count),
        .access_valid(access_valid)
    );

    function automatic logic [VW-1:0] model(input bit op, input bit z,
                                            input logic [LANES-1:0] m,
                                            input logic [VW-1:0] s,
                                            input logic [VW-1:0] o);
        logic [VW-1:0] r;
        int k;
        r = z ? '0 : o;
        k = 0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                if (op) r[k*EW +: EW] = s[i*EW +: EW];
                else    r[i*EW +: EW] = s[k*EW +: EW];
                k++;
            end
        end
        return r;
    endfunction

    function automatic int popc(input logic [LANES-1:0] m);
        int n = 0;
        for (int i = 0; i < LANES; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic logic [LANES-1:0] prefix(input int n);
        logic [LANES-1:0] v = '0;
        for (int i = 0; i < LANES; i++) v[i] = (i < n);
        return v;
    endfunction

    function automatic logic [VW-1:0] pattern(input logic [31:0] base);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*EW +: EW] = base + 32'(i * 32'h0101);
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one operation; returns cycles from accepting edge until done seen
    task automatic launch(input bit op, input bit z, input logic [LANES-1:0] m,
                          input logic [VW-1:0] s, input logic [VW-1:0] o,
                          input bit disturb, output int lat);
        @(negedge clk);
        op_compress = op; zeroing = z; mask = m; src_vec = s; old_vec = o;
        start = 1'b1;
        lat = 0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (disturb && lat == 4) begin
                start = 1'b1; op_compress = ~op; zeroing = ~z;
                mask = ~m; src_vec = ~s; old_vec = ~o;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    task automatic run_case(input string tag, input bit op, input bit z,
                            input logic [LANES-1:0] m, input logic [VW-1:0] s,
                            input logic [VW-1:0] o, input bit disturb);
        int lat;
        launch(op, z, m, s, o, disturb, lat);
        check_vec({tag, " result"}, result, model(op, z, m, s, o));
        check_int({tag, " R5 count"}, int'(count), popc(m));
        check_int({tag, " R6 access_valid"}, int'(access_valid), int'(prefix(popc(m))));
        check_int({tag, " R8 latency"}, lat, LATENCY);
        @(negedge clk);
        check_int({tag, " R8 done pulse"}, int'(done), 0);
        check_int({tag, " R8 busy released"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        check_int("R8 reset busy", int'(busy), 0);
        check_int("R8 reset done", int'(done), 0);
        check_int("R5 reset count", int'(count), 0);
        check_int("R6 reset access_valid", int'(access_valid), 0);
        check_vec("R10 reset result", result, '0);
    endtask

    task automatic t_expand_ref();
        logic [VW-1:0] s = pattern(32'hA000_0000);
        logic [VW-1:0] o = pattern(32'h0B00_0000);
        logic [LANES-1:0] lanes_hit [8] = '{0, 4, 5, 7, 8, 10, 11, 14};
        run_case("R1 expand 4DB1 merge", 1'b0, 1'b0, 16'h4DB1, s, o, 1'b0);
        for (int j = 0; j < 8; j++)
            check_int("R1 element placement", int'(result[int'(lanes_hit[j])*EW +: EW]), int'(s[j*EW +: EW]));
        check_int("R2 merge keeps lane 1", int'(result[1*EW +: EW]), int'(o[1*EW +: EW]));
    endtask

    task automatic t_expand_zero();
        run_case("R2 expand zeroing", 1'b0, 1'b1, 16'hA0C3,
                 pattern(32'h1111_0000), pattern(32'h2222_0000), 1'b0);
        check_int("R2 zeroed lane 2", int'(result[2*EW +: EW]), 0);
    endtask

    task automatic t_compress_merge();
        run_case("R3 R4 compress merge", 1'b1, 1'b0, 16'h4DB1,
                 pattern(32'h3300_0000), pattern(32'h4400_0000), 1'b0);
        check_int("R4 position 8 keeps old", int'(result[8*EW +: EW]), int'(32'h4400_0000 + 8*32'h0101));
    endtask

    task automatic t_compress_zero();
        run_case("R3 R4 compress zeroing", 1'b1, 1'b1, 16'h8001,
                 pattern(32'h5500_0000), pattern(32'h6600_0000), 1'b0);
        check_int("R3 position 1 from lane 15", int'(result[1*EW +: EW]), int'(32'h5500_0000 + 15*32'h0101));
    endtask

    task automatic t_empty_mask();
        run_case("R7 empty mask merge", 1'b0, 1'b0, 16'h0000,
                 pattern(32'h7700_0000), pattern(32'h8800_0000), 1'b0);
        check_vec("R7 result equals old", result, pattern(32'h8800_0000));
        run_case("R7 empty mask zeroing", 1'b1, 1'b1, 16'h0000,
                 pattern(32'h7700_0000), pattern(32'h8800_0000), 1'b0);
    endtask

    task automatic t_full_mask();
        run_case("R1 full mask expand", 1'b0, 1'b1, 16'hFFFF,
                 pattern(32'h9900_0000), pattern(32'hAA00_0000), 1'b0);
        run_case("R3 full mask compress", 1'b1, 1'b0, 16'hFFFF,
                 pattern(32'h9900_0000), pattern(32'hAA00_0000), 1'b0);
    endtask

    task automatic t_busy_ignored();
        run_case("R9 start while busy", 1'b0, 1'b0, 16'h0F0F,
                 pattern(32'hC000_0000), pattern(32'hD000_0000), 1'b1);
    endtask

    task automatic t_hold();
        logic [VW-1:0] exp = model(1'b1, 1'b0, 16'h1234, pattern(32'hE000_0000), pattern(32'hF000_0000));
        run_case("R10 setup", 1'b1, 1'b0, 16'h1234, pattern(32'hE000_0000), pattern(32'hF000_0000), 1'b0);
        @(negedge clk);
        mask = 16'hFFFF; src_vec = '1; old_vec = '0; zeroing = 1'b1; op_compress = 1'b0;
        repeat (5) @(negedge clk);
        check_vec("R10 result held", result, exp);
        check_int("R10 count held", int'(count), popc(16'h1234));
        check_int("R10 access_valid held", int'(access_valid), int'(prefix(popc(16'h1234))));
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_expand_ref();
        t_expand_zero();
        t_compress_merge();
        t_compress_zero();
        t_empty_mask();
        t_full_mask();
        t_busy_ignored();
        t_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule